// File: doc/BRIEF.md
# Temperature Measurement Controller

This block runs one on-chip temperature reading each time software writes a start request. The request sets a start flag that clears itself on the next clock edge, as the sequence takes over. The controller then switches on the sensor oscillator and lets it settle for a set number of frame periods. After that it counts the sensor's pulses for a fixed number of frame periods and stores the count as an 8-bit temperature code.

While a reading is running, the result register holds zero. When the reading finishes, the register takes a code that is never zero. Software can therefore read the register twice and treat any non-zero value as a finished reading. The code is centred on 128 at 27 °C, and one step is about 1.17 °C.

Readings run only while the chip is powered up and its clock is present. If either condition drops in the middle of a reading, the reading stops, the sensor is switched off and the register stays at zero. Frame ticks arrive as single-cycle pulses. Sensor pulses arrive already synchronised to `clk`, also one cycle each.

Top module: `tsense_ctrl`

## Requirements
- R1: After reset, `busy`, `sens_en` and `start_flag` are 0 and `result` is 0.
- R2: A `start_wr` strobe sets `start_flag` on the next edge when the block is idle and allowed to run. On the edge after that, the flag returns to 0 while `busy` rises.
- R3: `sens_en` is 1 exactly while `busy` is 1.
- R4: Sensor pulses that arrive during the warm-up phase are not counted. Warm-up ends on the WARM_FRAMES-th frame tick after `busy` rises.
- R5: The reading ends on the MEAS_FRAMES-th frame tick after warm-up. On that edge `busy` falls and `result` loads the count of pulses seen in the counting phase, including any pulse in that final cycle.
- R6: `result` reads 0 whenever `busy` is 1.
- R7: The loaded code is the pulse count clamped to the range 1 to 255. A count of 0 gives 1, and a count above 255 gives 255.
- R8: If `pwr_down` is 1, or `clk_ok` is 0, during a reading, `busy` and `sens_en` fall on the next edge and `result` stays 0.
- R9: A `start_wr` strobe while `busy` is 1 is ignored: no second reading follows.
- R10: A `start_wr` strobe while `pwr_down` is 1 or `clk_ok` is 0 leaves `start_flag`, `busy` and `result` unchanged.
- R11: While idle, `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame period |
| sens_pulse | input | 1 | One-cycle pulse per sensor oscillator period |
| start_wr | input | 1 | Software write of the start bit |
| pwr_down | input | 1 | Power-down mode active |
| clk_ok | input | 1 | Measurement clock is present |
| sens_en | output | 1 | Sensor oscillator enable |
| busy | output | 1 | Reading in progress |
| start_flag | output | 1 | Self-clearing start bit, readable |
| result | output | 8 | Temperature code; 0 while running |

## Verification
`start_flag` is due one edge after the strobe, and `busy` and `sens_en` one edge after that. The result is due on the edge that samples the final frame tick, and an abort takes effect one edge after `pwr_down` or a lost clock is sampled. The bench changes every input just after a falling edge and reads the outputs at the next falling edge. This puts each read exactly one register stage after the stimulus. A scoreboard queue holds the expected code of each reading, and the monitor removes one entry whenever it sees `busy` fall.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_WARM = 2'd1,
    TS_MEAS = 2'd2
  } ts_state_e;
endpackage

// File: rtl/tsense_seq.sv
module tsense_seq
  import tsense_pkg::*;
#(
  parameter int WARM_FRAMES = 2,
  parameter int MEAS_FRAMES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_tick,
  input  logic      start_wr,
  input  logic      pwr_down,
  input  logic      clk_ok,
  output ts_state_e state,
  output logic      start_flag,
  output logic      sens_en,
  output logic      go,
  output logic      fin
);
  localparam int MAX_FRAMES = (WARM_FRAMES > MEAS_FRAMES) ? WARM_FRAMES : MEAS_FRAMES;
  localparam int FC_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1;
  localparam logic [FC_W-1:0] WARM_LAST = FC_W'(WARM_FRAMES - 1);
  localparam logic [FC_W-1:0] MEAS_LAST = FC_W'(MEAS_FRAMES - 1);

  ts_state_e       state_nxt;
  logic [FC_W-1:0] fcnt, fcnt_nxt;
  logic            flag_nxt, en_nxt, run_ok;

  assign run_ok = !pwr_down && clk_ok;

  always_comb begin
    state_nxt = state;
    fcnt_nxt  = fcnt;
    go        = 1'b0;
    fin       = 1'b0;
    flag_nxt  = start_wr && (state == TS_IDLE) && !start_flag && run_ok;
    unique case (state)
      TS_IDLE: begin
        if (start_flag && run_ok) begin
          state_nxt = TS_WARM;
          fcnt_nxt  = '0;
          go        = 1'b1;
        end
      end
      TS_WARM: begin
        if (!run_ok) begin
          state_nxt = TS_IDLE;
        end else if (frame_tick) begin
          if (fcnt == WARM_LAST) begin
            state_nxt = TS_MEAS;
            fcnt_nxt  = '0;
          end else begin
            fcnt_nxt = fcnt + 1'b1;
          end
        end
      end
      TS_MEAS: begin
        if (!run_ok) begin
          state_nxt = TS_IDLE;
        end else if (frame_tick) begin
          if (fcnt == MEAS_LAST) begin
            state_nxt = TS_IDLE;
            fin       = 1'b1;
          end else begin
            fcnt_nxt = fcnt + 1'b1;
          end
        end
      end
      default: state_nxt = TS_IDLE;
    endcase
    en_nxt = (state_nxt != TS_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TS_IDLE;
      fcnt       <= '0;
      start_flag <= 1'b0;
      sens_en    <= 1'b0;
    end else begin
      state      <= state_nxt;
      fcnt       <= fcnt_nxt;
      start_flag <= flag_nxt;
      sens_en    <= en_nxt;
    end
  end
endmodule

// File: rtl/tsense_cnt.sv
module tsense_cnt #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             pulse,
  output logic [RES_W-1:0] code
);
  localparam logic [RES_W-1:0] CNT_MAX = {RES_W{1'b1}};
  localparam logic [RES_W-1:0] CODE_MIN = RES_W'(1);

  logic [RES_W-1:0] cnt, cnt_nxt;
  logic             cnt_ce;

  always_comb begin
    cnt_nxt = cnt;
    if (en && pulse && (cnt != CNT_MAX)) cnt_nxt = cnt + 1'b1;
    if (clr) cnt_nxt = '0;
    cnt_ce = clr || en;
  end

  // Code presented for loading includes a pulse in the current cycle.
  always_comb begin
    code = (cnt_nxt == '0) ? CODE_MIN : cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_ce) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tsense_result.sv
module tsense_result #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] q
);
  logic [RES_W-1:0] q_nxt;
  logic             q_ce;

  always_comb begin
    q_ce  = clr || load;
    q_nxt = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (q_ce) q <= q_nxt;
  end
endmodule

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
  import tsense_pkg::*;
#(
  parameter int WARM_FRAMES = 2,
  parameter int MEAS_FRAMES = 2,
  parameter int RES_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             sens_pulse,
  input  logic             start_wr,
  input  logic             pwr_down,
  input  logic             clk_ok,
  output logic             sens_en,
  output logic             busy,
  output logic             start_flag,
  output logic [RES_W-1:0] result
);
  ts_state_e        state;
  logic             go, fin, counting;
  logic [RES_W-1:0] code;

  tsense_seq #(
    .WARM_FRAMES(WARM_FRAMES),
    .MEAS_FRAMES(MEAS_FRAMES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .start_wr(start_wr),
    .pwr_down(pwr_down), .clk_ok(clk_ok), .state(state),
    .start_flag(start_flag), .sens_en(sens_en), .go(go), .fin(fin)
  );

  assign counting = (state == TS_MEAS);
  assign busy     = (state != TS_IDLE);

  tsense_cnt #(.RES_W(RES_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(go), .en(counting),
    .pulse(sens_pulse), .code(code)
  );

  tsense_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(go), .load(fin), .din(code), .q(result)
  );
endmodule

// File: rtl/tsense_ctrl_chk.sv
module tsense_ctrl_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             clk_ok,
  input logic             busy,
  input logic             sens_en,
  input logic             start_flag,
  input logic [RES_W-1:0] result
);
  a_r3_enable_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sens_en == busy);

  a_r6_zero_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (result == '0));

  a_r2_flag_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_flag |=> !start_flag);

  a_r8_abort_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (pwr_down || !clk_ok)) |=> !busy);

  a_r7_done_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(pwr_down) && $past(clk_ok)) |-> (result != '0));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(result));
endmodule

bind tsense_ctrl tsense_ctrl_chk #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .clk_ok(clk_ok),
  .busy(busy), .sens_en(sens_en), .start_flag(start_flag), .result(result)
);

// File: tb/test_tsense_ctrl.sv
module test_tsense_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0, sens_pulse = 1'b0, start_wr = 1'b0;
  logic       pwr_down = 1'b0, clk_ok = 1'b1;
  logic       sens_en, busy, start_flag;
  logic [7:0] result;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  bit finished = 1'b0;
  logic busy_q = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsense_ctrl i_tsense_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .sens_pulse(sens_pulse),
    .start_wr(start_wr), .pwr_down(pwr_down), .clk_ok(clk_ok),
    .sens_en(sens_en), .busy(busy), .start_flag(start_flag), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sens_pulse = 1'b1;
      @(negedge clk);
      sens_pulse = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic begin_read();
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    chk(start_flag == 1'b1, "R2 flag set", start_flag, 1);
    @(negedge clk);
    chk(start_flag == 1'b0 && busy == 1'b1, "R2 flag clears as busy rises",
        {start_flag, busy}, 1);
    chk(sens_en == 1'b1, "R3 sensor enabled", sens_en, 1);
    chk(result == 8'd0, "R6 result zero while busy", result, 0);
  endtask

  task automatic full_read(input int warm_p, input int meas_p, input bit poke_start);
    int e;
    e = (meas_p == 0) ? 1 : ((meas_p > 255) ? 255 : meas_p);
    exp_q.push_back(e);
    begin_read();
    pulses(warm_p);
    tick();
    pulses(warm_p);
    tick();
    if (poke_start) begin
      start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
    end
    pulses(meas_p);
    tick();
    chk(busy == 1'b1 && result == 8'd0, "R5 still running after first count tick",
        result, 0);
    tick();
    chk(busy == 1'b0 && sens_en == 1'b0, "R5 done on last tick", {busy, sens_en}, 0);
    chk(result == e[7:0], "R7 clamped code", result, e);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && busy_q && !busy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected end of reading", result, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(result == e[7:0], "R7 scoreboard result", result, e);
      end
    end
    busy_q <= busy;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(busy == 0 && sens_en == 0 && start_flag == 0 && result == 0, "R1 reset state",
        {busy, sens_en, start_flag, result}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R4: warm-up pulses excluded; R7 plain count
    full_read(5, 100, 1'b0);
    // R11: result holds while idle
    cyc(5);
    chk(result == 8'd100, "R11 result held", result, 100);

    // R7 lower clamp
    full_read(0, 0, 1'b0);
    // R7 upper clamp
    full_read(3, 300, 1'b0);

    // R9: start during measurement ignored
    full_read(0, 7, 1'b1);
    cyc(4);
    chk(busy == 1'b0 && start_flag == 1'b0, "R9 no second reading",
        {busy, start_flag}, 0);

    // R8: power-down abort during warm-up
    exp_q.push_back(0);
    begin_read();
    tick();
    pwr_down = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && sens_en == 1'b0, "R8 abort on power-down", {busy, sens_en}, 0);
    chk(result == 8'd0, "R8 result left zero", result, 0);
    pwr_down = 1'b0;
    cyc(2);

    // R8: lost clock during counting
    exp_q.push_back(0);
    begin_read();
    tick();
    tick();
    pulses(4);
    clk_ok = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && result == 8'd0, "R8 abort on lost clock", result, 0);
    clk_ok = 1'b1;
    cyc(2);

    // R10: start blocked in power-down and with no clock
    full_read(0, 42, 1'b0);
    pwr_down = 1'b1;
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    cyc(3);
    chk(start_flag == 0 && busy == 0 && result == 8'd42, "R10 start in power-down",
        result, 42);
    pwr_down = 1'b0;
    clk_ok = 1'b0;
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    cyc(3);
    chk(start_flag == 0 && busy == 0 && result == 8'd42, "R10 start with no clock",
        result, 42);
    clk_ok = 1'b1;
    cyc(2);

    chk(exp_q.size() == 0, "R5 all readings completed", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule